// File: doc/BRIEF.md
# GPIO Edge/Level Interrupt Controller

This block watches 32 general-purpose input pins and turns their activity into a single interrupt request for an upstream interrupt controller. Every pin is configured on its own. It can detect a level or an edge. A level can be active-high or active-low. An edge can be rising, falling or both. The pin's pending flag can either latch the event until software clears it or simply follow the detected condition every cycle.

A processor reaches the block through a synchronous 16-bit register port. Each per-pin property is held in a pair of registers: the lower register of a pair serves pins 0–15, and the upper one, two bytes higher, serves pins 16–31 at bit (pin − 16). Pending flags are cleared by writing ones. A read-only index register names the lowest-numbered pin that is both pending and enabled, so an interrupt handler can dispatch without scanning. A general I/O-select register pair is kept as plain storage for the surrounding pin logic.

Pin inputs are treated as asynchronous and pass through a two-stage synchronizer. Edges are found by comparing the two most recent synchronized samples.

Top module: `gpint_ctrl`

## Requirements
- R1: After reset every register reads zero, `irq_o` is low, and the index register at byte offset 0x28 reads 0x003F. In that register bit 15 is the valid flag and bits 5:0 are the pin index.
- R2: The registers sit at these byte offsets, with the lower/upper halves at +0/+2: enable 0x0C, edge-type select 0x10, polarity 0x14, hold select 0x18, falling-edge enable 0x20, rising-edge enable 0x24, I/O select 0x00 and pending status 0x08. Pin n (n<16) uses bit n of the lower register and pin n≥16 uses bit n−16 of the upper one. Read data appears on `rd_data_o` one cycle after `rd_en_i` and is zero when `rd_en_i` was low.
- R3: A pin change driven before clock edge k is reflected in the pending status, and so in `irq_o`, after edge k+2.
- R4: With the type bit at 0 (level), a pin is detected while its synchronized level equals its polarity bit (1 = active-high, 0 = active-low).
- R5: With the hold bit at 0, a pin's pending flag equals the detection of the previous cycle, and a write-one-to-clear has no lasting effect while the condition persists.
- R6: With the type bit at 1 (edge), a 0→1 change is detected only if the rising-enable bit is 1, and a 1→0 change only if the falling-enable bit is 1. With both bits set, both changes are detected.
- R7: With the hold bit at 1, a detected event stays pending until a 1 is written to its status bit. Writing 0 to a status bit leaves it unchanged.
- R8: When a detection and a write-one-to-clear of the same pin fall in the same cycle, the pin stays pending.
- R9: `irq_o` is high exactly when some pin has both its pending flag and its enable bit set.
- R10: The index register gives the lowest-numbered pin that is pending and enabled, with bit 15 set. Any such pin in 0–15 wins over every pin in 16–31. With none, it reads 0x003F.
- R11: Writes to unmapped or odd byte offsets and writes to 0x28 change no register. Reads from them return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | 32 | Asynchronous pin inputs |
| addr_i | input | 8 | Register byte offset |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 16 | Register write data |
| rd_en_i | input | 1 | Register read strobe |
| rd_data_o | output | 16 | Registered read data, valid the cycle after `rd_en_i` |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The delays follow from the register chain. A register write takes effect at the edge that samples it. A read returns data after the edge that samples `rd_en_i`. A pin change reaches the pending flag and `irq_o` two edges after the edge that first samples it. Detection in any cycle uses the configuration that was in place before that cycle's write. The bench models this behaviour cycle by cycle, updating the model on the rising edge and comparing `irq_o` and `rd_data_o` against it on every falling edge. The directed checks wait an explicit number of edges: the synchronizer latency is checked on each of the three edges that follow a pin change, and the other results are sampled only once their cycle is known to have passed.

// File: rtl/gpint_pkg.sv
`timescale 1ns/1ps
package gpint_pkg;
    localparam int DATA_W  = 16;
    localparam int ADDR_W  = 8;
    localparam int NUM_CFG = 7;

    // byte offsets of the lower half of each register pair
    localparam int OFS_IOSEL = 'h00;
    localparam int OFS_STAT  = 'h08;
    localparam int OFS_EN    = 'h0C;
    localparam int OFS_TYPE  = 'h10;
    localparam int OFS_POL   = 'h14;
    localparam int OFS_HOLD  = 'h18;
    localparam int OFS_FALL  = 'h20;
    localparam int OFS_RISE  = 'h24;
    localparam int OFS_PRIO  = 'h28;

    // plain configuration registers come first so they index the storage array
    typedef enum logic [3:0] {
        SEL_IOSEL = 4'd0,
        SEL_EN    = 4'd1,
        SEL_TYPE  = 4'd2,
        SEL_POL   = 4'd3,
        SEL_HOLD  = 4'd4,
        SEL_FALL  = 4'd5,
        SEL_RISE  = 4'd6,
        SEL_STAT  = 4'd7,
        SEL_PRIO  = 4'd8,
        SEL_NONE  = 4'd9
    } reg_sel_e;
endpackage

// File: rtl/gpint_sync.sv
`timescale 1ns/1ps
module gpint_sync #(
    parameter int N = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] async_i,
    output logic [N-1:0] sync_o
);
    logic [N-1:0] meta_q;
    logic [N-1:0] stab_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            stab_q <= '0;
        end else begin
            meta_q <= async_i;
            stab_q <= meta_q;
        end
    end

    assign sync_o = stab_q;
endmodule

// File: rtl/gpint_detect.sv
`timescale 1ns/1ps
module gpint_detect #(
    parameter int N = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] smp_i,
    input  logic [N-1:0] typ_i,
    input  logic [N-1:0] pol_i,
    input  logic [N-1:0] hold_i,
    input  logic [N-1:0] fall_i,
    input  logic [N-1:0] rise_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] sts_o
);
    logic [N-1:0] prev_q;
    logic [N-1:0] sts_q;
    logic [N-1:0] det;
    logic [N-1:0] sts_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= '0;
            sts_q  <= '0;
        end else begin
            prev_q <= smp_i;
            sts_q  <= sts_d;
        end
    end

    for (genvar g = 0; g < N; g++) begin : g_pin
        logic went_up;
        logic went_down;
        logic lvl_hit;
        logic edge_hit;
        assign went_up   = smp_i[g] & ~prev_q[g];
        assign went_down = ~smp_i[g] & prev_q[g];
        assign lvl_hit   = ~(smp_i[g] ^ pol_i[g]);
        assign edge_hit  = (went_up & rise_i[g]) | (went_down & fall_i[g]);
        assign det[g]    = typ_i[g] ? edge_hit : lvl_hit;
        // a fresh detection overrides a same-cycle clear
        assign sts_d[g]  = hold_i[g] ? (det[g] | (sts_q[g] & ~clr_i[g])) : det[g];
    end

    assign sts_o = sts_q;

    // R5: through pins carry last cycle's detection
    p_through_tracks_r5: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (((sts_q ^ $past(det)) & ~$past(hold_i)) == '0));

    // R7: a held flag survives any cycle without a clear
    p_hold_keeps_r7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(sts_q & hold_i & ~clr_i) & ~sts_q) == '0));

    // R8: a detection on a hold pin always lands
    p_detect_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(det & hold_i) & ~sts_q) == '0));
endmodule

// File: rtl/gpint_prio.sv
`timescale 1ns/1ps
module gpint_prio #(
    parameter int N  = 32,
    parameter int IW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  act_i,
    output logic [IW-1:0] idx_o,
    output logic          vld_o
);
    always_comb begin
        idx_o = '1;
        vld_o = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (act_i[i]) begin
                idx_o = IW'(i);
                vld_o = 1'b1;
            end
        end
    end

    // R10: the chosen pin is active and no lower pin is
    p_prio_lowest_r10: assert property (@(posedge clk) disable iff (!rst_n)
        vld_o |-> (act_i[idx_o[IW-2:0]] && ((act_i & ~({N{1'b1}} << idx_o)) == '0)));

    // R10: the empty code only when nothing is active
    p_prio_empty_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !vld_o |-> (idx_o == '1 && act_i == '0));
endmodule

// File: rtl/gpint_ctrl.sv
`timescale 1ns/1ps
module gpint_ctrl #(
    parameter int DW = gpint_pkg::DATA_W,
    parameter int AW = gpint_pkg::ADDR_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [2*DW-1:0] pin_i,
    input  logic [AW-1:0]   addr_i,
    input  logic            wr_en_i,
    input  logic [DW-1:0]   wr_data_i,
    input  logic            rd_en_i,
    output logic [DW-1:0]   rd_data_o,
    output logic            irq_o
);
    import gpint_pkg::*;

    localparam int PINS = 2 * DW;
    localparam int IW   = $clog2(PINS) + 1;
    localparam int NCFG = NUM_CFG;
    localparam int PADW = DW - 1 - IW;

    reg_sel_e        sel;
    logic            hi_half;
    logic [PINS-1:0] cfg_q [NCFG];
    logic [PINS-1:0] en_q;
    logic [PINS-1:0] typ_q;
    logic [PINS-1:0] pol_q;
    logic [PINS-1:0] hold_q;
    logic [PINS-1:0] fall_q;
    logic [PINS-1:0] rise_q;
    logic [PINS-1:0] smp;
    logic [PINS-1:0] clr;
    logic [PINS-1:0] sts;
    logic [PINS-1:0] act;
    logic [IW-1:0]   prio_idx;
    logic            prio_vld;
    logic [DW-1:0]   prio_word;
    logic [PINS-1:0] rd_full;
    logic [DW-1:0]   rd_val;

    // address decode
    always_comb begin
        sel     = SEL_NONE;
        hi_half = addr_i[1];
        if (!addr_i[0]) begin
            case ({addr_i[AW-1:2], 2'b00})
                AW'(OFS_IOSEL): sel = SEL_IOSEL;
                AW'(OFS_STAT):  sel = SEL_STAT;
                AW'(OFS_EN):    sel = SEL_EN;
                AW'(OFS_TYPE):  sel = SEL_TYPE;
                AW'(OFS_POL):   sel = SEL_POL;
                AW'(OFS_HOLD):  sel = SEL_HOLD;
                AW'(OFS_FALL):  sel = SEL_FALL;
                AW'(OFS_RISE):  sel = SEL_RISE;
                AW'(OFS_PRIO):  sel = hi_half ? SEL_NONE : SEL_PRIO;
                default:        sel = SEL_NONE;
            endcase
        end
    end

    // configuration register pairs
    for (genvar g = 0; g < NCFG; g++) begin : g_cfg
        logic [PINS-1:0] q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                q <= '0;
            end else if (wr_en_i && sel == reg_sel_e'(g)) begin
                if (hi_half) q[PINS-1:DW] <= wr_data_i;
                else         q[DW-1:0]    <= wr_data_i;
            end
        end
        assign cfg_q[g] = q;
    end

    assign en_q   = cfg_q[int'(SEL_EN)];
    assign typ_q  = cfg_q[int'(SEL_TYPE)];
    assign pol_q  = cfg_q[int'(SEL_POL)];
    assign hold_q = cfg_q[int'(SEL_HOLD)];
    assign fall_q = cfg_q[int'(SEL_FALL)];
    assign rise_q = cfg_q[int'(SEL_RISE)];

    // write-one-to-clear mask for the pending flags
    assign clr = (wr_en_i && sel == SEL_STAT)
               ? (hi_half ? {wr_data_i, {DW{1'b0}}} : {{DW{1'b0}}, wr_data_i})
               : '0;

    gpint_sync #(.N(PINS)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (pin_i),
        .sync_o  (smp)
    );

    gpint_detect #(.N(PINS)) u_detect (
        .clk    (clk),
        .rst_n  (rst_n),
        .smp_i  (smp),
        .typ_i  (typ_q),
        .pol_i  (pol_q),
        .hold_i (hold_q),
        .fall_i (fall_q),
        .rise_i (rise_q),
        .clr_i  (clr),
        .sts_o  (sts)
    );

    assign act = sts & en_q;

    gpint_prio #(.N(PINS), .IW(IW)) u_prio (
        .clk   (clk),
        .rst_n (rst_n),
        .act_i (act),
        .idx_o (prio_idx),
        .vld_o (prio_vld)
    );

    assign prio_word = {prio_vld, {PADW{1'b0}}, prio_idx};
    assign irq_o     = |act;

    // read mux
    always_comb begin
        rd_full = '0;
        for (int g = 0; g < NCFG; g++) begin
            if (sel == reg_sel_e'(g)) rd_full = cfg_q[g];
        end
        if (sel == SEL_STAT) rd_full = sts;
        rd_val = hi_half ? rd_full[PINS-1:DW] : rd_full[DW-1:0];
        if (sel == SEL_PRIO) rd_val = prio_word;
        if (sel == SEL_NONE) rd_val = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_data_o <= '0;
        else        rd_data_o <= rd_en_i ? rd_val : '0;
    end

    // R1: the first cycle out of reset starts from a blank configuration
    p_reset_blank_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (en_q == '0 && typ_q == '0 && hold_q == '0 && rd_data_o == '0 && !irq_o));

    // R9: a request needs at least one enabled pin
    p_irq_needs_enable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (en_q != '0));
endmodule

// File: tb/gpint_ctrl_test.sv
`timescale 1ns/1ps
module gpint_ctrl_test;
    localparam int DW = 16;
    localparam int AW = 8;
    localparam int NP = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NP-1:0] pins = '0;
    logic [AW-1:0] b_addr = '0;
    logic          b_wr = 1'b0;
    logic          b_rd = 1'b0;
    logic [DW-1:0] b_wdata = '0;
    logic [DW-1:0] rd_data;
    logic          irq;

    int    checks = 0;
    int    errors = 0;
    string cur_req = "R1";
    bit    done = 1'b0;

    always #2.5 clk = ~clk;

    gpint_ctrl #(.DW(DW), .AW(AW)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_i     (pins),
        .addr_i    (b_addr),
        .wr_en_i   (b_wr),
        .wr_data_i (b_wdata),
        .rd_en_i   (b_rd),
        .rd_data_o (rd_data),
        .irq_o     (irq)
    );

    // behavioural reference model
    logic [31:0] m_s1, m_s2, m_s3, m_sts;
    logic [31:0] m_io, m_en, m_typ, m_pol, m_hold, m_fe, m_re;
    logic [15:0] m_rd;

    function automatic logic [15:0] m_prio();
        for (int i = 0; i < 32; i++)
            if (m_sts[i] && m_en[i]) return 16'h8000 | 16'(i);
        return 16'h003F;
    endfunction

    function automatic logic [15:0] m_read(input logic [7:0] a);
        logic [31:0] w;
        w = '0;
        if (a[0]) return 16'h0;
        case ({a[7:2], 2'b00})
            8'h00: w = m_io;
            8'h08: w = m_sts;
            8'h0C: w = m_en;
            8'h10: w = m_typ;
            8'h14: w = m_pol;
            8'h18: w = m_hold;
            8'h20: w = m_fe;
            8'h24: w = m_re;
            8'h28: return a[1] ? 16'h0 : m_prio();
            default: return 16'h0;
        endcase
        return a[1] ? w[31:16] : w[15:0];
    endfunction

    always @(posedge clk) begin
        logic [31:0] nsts;
        logic [31:0] clrm;
        if (!rst_n) begin
            m_s1 = '0; m_s2 = '0; m_s3 = '0; m_sts = '0; m_rd = '0;
            m_io = '0; m_en = '0; m_typ = '0; m_pol = '0; m_hold = '0; m_fe = '0; m_re = '0;
        end else begin
            clrm = '0;
            if (b_wr && b_addr == 8'h08) clrm[15:0]  = b_wdata;
            if (b_wr && b_addr == 8'h0A) clrm[31:16] = b_wdata;
            for (int p = 0; p < 32; p++) begin
                bit cur, old, hit;
                cur = m_s2[p];
                old = m_s3[p];
                if (m_typ[p]) hit = (cur && !old && m_re[p]) || (!cur && old && m_fe[p]);
                else          hit = m_pol[p] ? cur : !cur;
                nsts[p] = m_hold[p] ? (hit || (m_sts[p] && !clrm[p])) : hit;
            end
            m_rd = b_rd ? m_read(b_addr) : 16'h0;
            if (b_wr && !b_addr[0]) begin
                case ({b_addr[7:2], 2'b00})
                    8'h00: if (b_addr[1]) m_io[31:16]   = b_wdata; else m_io[15:0]   = b_wdata;
                    8'h0C: if (b_addr[1]) m_en[31:16]   = b_wdata; else m_en[15:0]   = b_wdata;
                    8'h10: if (b_addr[1]) m_typ[31:16]  = b_wdata; else m_typ[15:0]  = b_wdata;
                    8'h14: if (b_addr[1]) m_pol[31:16]  = b_wdata; else m_pol[15:0]  = b_wdata;
                    8'h18: if (b_addr[1]) m_hold[31:16] = b_wdata; else m_hold[15:0] = b_wdata;
                    8'h20: if (b_addr[1]) m_fe[31:16]   = b_wdata; else m_fe[15:0]   = b_wdata;
                    8'h24: if (b_addr[1]) m_re[31:16]   = b_wdata; else m_re[15:0]   = b_wdata;
                    default: ;
                endcase
            end
            m_sts = nsts;
            m_s3 = m_s2;
            m_s2 = m_s1;
            m_s1 = pins;
        end
    end

    // per-cycle comparison against the model (R9 for the request, R2 for reads)
    always @(negedge clk) begin
        if (rst_n && !done) begin
            checks++;
            if (irq !== |(m_sts & m_en)) begin
                errors++;
                $display("FAIL %s irq actual %0b expected %0b", cur_req, irq, |(m_sts & m_en));
            end
            checks++;
            if (rd_data !== m_rd) begin
                errors++;
                $display("FAIL %s rd_data actual %h expected %h", cur_req, rd_data, m_rd);
            end
        end
    end

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [15:0] d);
        @(negedge clk);
        b_addr = a; b_wdata = d; b_wr = 1'b1;
        @(negedge clk);
        b_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [15:0] d);
        @(negedge clk);
        b_addr = a; b_rd = 1'b1;
        @(negedge clk);
        b_rd = 1'b0;
        d = rd_data;
    endtask

    task automatic setpin(input int p, input logic v);
        @(negedge clk);
        pins[p] = v;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual running expected finished");
            finish_run();
        end
    end

    initial begin
        logic [15:0] d;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        cur_req = "R1";
        rd(8'h28, d); chk("R1 index after reset", d, 16'h003F);
        rd(8'h0C, d); chk("R1 enable after reset", d, 16'h0000);
        rd(8'h18, d); chk("R1 hold after reset", d, 16'h0000);
        chk("R1 irq after reset", 16'(irq), 16'h0);

        // R2: register halves and read-back
        cur_req = "R2";
        wr(8'h10, 16'hA5A5); wr(8'h12, 16'h5A5A); wr(8'h02, 16'h1234);
        rd(8'h10, d); chk("R2 type low", d, 16'hA5A5);
        rd(8'h12, d); chk("R2 type high", d, 16'h5A5A);
        rd(8'h02, d); chk("R2 io-select high", d, 16'h1234);
        rd(8'h00, d); chk("R2 io-select low", d, 16'h0000);
        wr(8'h10, 16'h0000); wr(8'h12, 16'h0000);

        // R3 and R4: level polarity and synchronizer latency on pin 3
        cur_req = "R3";
        wr(8'h14, 16'h0008); wr(8'h0C, 16'h0008);
        idle(3);
        chk("R4 active-high pin low gives no irq", 16'(irq), 16'h0);
        @(negedge clk); pins[3] = 1'b1;
        @(negedge clk); chk("R3 one edge after change", 16'(irq), 16'h0);
        @(negedge clk); chk("R3 two edges after change", 16'(irq), 16'h0);
        @(negedge clk); chk("R3 three edges after change", 16'(irq), 16'h1);
        cur_req = "R4";
        rd(8'h08, d); chk("R4 status low word", d, 16'hFFFF);
        wr(8'h0E, 16'h0010);
        idle(3);
        rd(8'h28, d); chk("R10 low half wins", d, 16'h8003);
        setpin(3, 1'b0); idle(4);
        rd(8'h28, d); chk("R4 active-low pin 20 indexed", d, 16'h8014);
        rd(8'h08, d); chk("R4 pin 3 released", d, 16'hFFF7);

        // R5: through mode ignores clear while condition persists
        cur_req = "R5";
        wr(8'h0A, 16'h0010); idle(1);
        rd(8'h0A, d); chk("R5 clear has no lasting effect", d, 16'hFFFF);
        chk("R5 irq stays", 16'(irq), 16'h1);
        setpin(20, 1'b1); idle(4);
        rd(8'h0A, d); chk("R5 status follows condition", d, 16'hFFEF);
        rd(8'h28, d); chk("R10 no active pin", d, 16'h003F);

        // R6 and R7: edge selection on pin 5 with hold
        cur_req = "R6";
        wr(8'h0C, 16'h0000); wr(8'h0E, 16'h0000);
        wr(8'h10, 16'h0020); wr(8'h18, 16'h0020); wr(8'h24, 16'h0020); wr(8'h20, 16'h0000);
        idle(3);
        wr(8'h08, 16'h0020); idle(2);
        wr(8'h0C, 16'h0020); idle(2);
        chk("R6 no edge yet", 16'(irq), 16'h0);
        setpin(5, 1'b1); idle(4);
        chk("R6 rising detected", 16'(irq), 16'h1);
        rd(8'h28, d); chk("R10 pin 5 indexed", d, 16'h8005);
        cur_req = "R7";
        wr(8'h08, 16'h0000); idle(2);
        chk("R7 writing zero keeps flag", 16'(irq), 16'h1);
        wr(8'h08, 16'h0020); idle(2);
        chk("R7 write-one clears", 16'(irq), 16'h0);
        cur_req = "R6";
        setpin(5, 1'b0); idle(4);
        chk("R6 falling ignored in rising mode", 16'(irq), 16'h0);
        wr(8'h24, 16'h0000); wr(8'h20, 16'h0020);
        setpin(5, 1'b1); idle(4);
        chk("R6 rising ignored in falling mode", 16'(irq), 16'h0);
        setpin(5, 1'b0); idle(4);
        chk("R6 falling detected", 16'(irq), 16'h1);
        wr(8'h08, 16'h0020); idle(2);
        wr(8'h24, 16'h0020);
        setpin(5, 1'b1); idle(4);
        chk("R6 both: rising", 16'(irq), 16'h1);
        wr(8'h08, 16'h0020); idle(2);
        chk("R6 both: cleared", 16'(irq), 16'h0);
        setpin(5, 1'b0); idle(4);
        chk("R6 both: falling", 16'(irq), 16'h1);
        wr(8'h08, 16'h0020);
        cur_req = "R5";
        wr(8'h18, 16'h0000);
        setpin(5, 1'b1); idle(4);
        chk("R5 edge pulse gone in through mode", 16'(irq), 16'h0);

        // R8: detection beats same-cycle clear on pin 7 (level, hold)
        cur_req = "R8";
        wr(8'h0C, 16'h0000);
        wr(8'h14, 16'h0088); wr(8'h18, 16'h0080);
        setpin(7, 1'b1);
        wr(8'h0C, 16'h0080); idle(4);
        chk("R8 pending before clear", 16'(irq), 16'h1);
        wr(8'h08, 16'h0080); idle(2);
        chk("R8 detection wins over clear", 16'(irq), 16'h1);
        cur_req = "R7";
        setpin(7, 1'b0); idle(4);
        chk("R7 latched after condition ends", 16'(irq), 16'h1);
        wr(8'h08, 16'h0080); idle(2);
        chk("R7 latched flag cleared", 16'(irq), 16'h0);

        // R9: pending without enable gives no request
        cur_req = "R9";
        wr(8'h0C, 16'h0000); idle(2);
        rd(8'h08, d); chk("R9 pin 0 pending", d & 16'h0001, 16'h0001);
        chk("R9 no irq without enable", 16'(irq), 16'h0);

        // R10: ordering inside the upper half
        cur_req = "R10";
        wr(8'h16, 16'h8002); wr(8'h0E, 16'h8002);
        @(negedge clk); pins[17] = 1'b1; pins[31] = 1'b1;
        idle(4);
        rd(8'h28, d); chk("R10 pin 17 before 31", d, 16'h8011);
        setpin(17, 1'b0); idle(4);
        rd(8'h28, d); chk("R10 pin 31 alone", d, 16'h801F);
        wr(8'h0C, 16'h0001); idle(2);
        rd(8'h28, d); chk("R10 pin 0 wins", d, 16'h8000);

        // R11: unmapped, odd and read-only offsets
        cur_req = "R11";
        wr(8'h04, 16'hFFFF); wr(8'h28, 16'h1234); wr(8'h0D, 16'hFFFF); wr(8'h1C, 16'hFFFF);
        rd(8'h04, d); chk("R11 unmapped reads zero", d, 16'h0000);
        rd(8'h0C, d); chk("R11 enable untouched by odd write", d, 16'h0001);
        rd(8'h2A, d); chk("R11 upper index offset reads zero", d, 16'h0000);
        rd(8'h28, d); chk("R11 index write ignored", d, 16'h8000);
        rd(8'h1C, d); chk("R11 gap offset reads zero", d, 16'h0000);

        idle(2);
        finish_run();
    end
endmodule